// File: doc/BRIEF.md
# Synchronous Presettable Binary Counter

This block is a binary up-counter in which every control takes effect on the rising clock edge. Its control inputs are an active-low clear, an active-low parallel preset, and two count enables. A clear drives the count to zero. A preset copies a parallel value into the register. When neither clear nor preset is active, the register counts up if both enables are high and holds its value otherwise. The modes resolve by fixed priority: clear, then preset, then count, then hold.

A combinational terminal-count output is high when the register is all ones and the chain enable is high. Feeding it into the chain enable of the next stage builds a wider counter, and all stages share one clock. The controls are plain level pins with no handshake, because the register acts on each edge as described above. The default width is 4 bits.

Top module: `sync_preset_counter`

## Requirements
- R1: If `zero_n` is 0 at a rising edge, `count` is 0 after that edge, whatever `preset_n`, `cnt_en`, `chain_en` and `preset_val` are.
- R2: The clear is synchronous. Driving `zero_n` low between edges leaves `count` unchanged until the next rising edge.
- R3: If `zero_n` is 1 and `preset_n` is 0 at a rising edge, `count` takes the value of `preset_val` after that edge, whatever the enables are.
- R4: If `zero_n`, `preset_n`, `cnt_en` and `chain_en` are all 1 at a rising edge, `count` increases by one.
- R5: If `zero_n` and `preset_n` are 1 and at least one of `cnt_en` or `chain_en` is 0 at a rising edge, `count` keeps its value.
- R6: Incrementing from all ones (15 for the default width) gives 0.
- R7: `term` is 1 exactly when `count` is all ones and `chain_en` is 1. It follows `chain_en` combinationally, with no clock edge needed.
- R8: Two stages chained through `term` form a counter twice as wide. The high stage's `chain_en` is driven by the low stage's `term`, both stages share `cnt_en`, and the pair counts as one binary value with the high stage as the upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| zero_n | input | 1 | Synchronous clear, active low, highest priority |
| preset_n | input | 1 | Synchronous parallel preset, active low |
| cnt_en | input | 1 | Count enable, does not gate `term` |
| chain_en | input | 1 | Count enable that also gates `term` (cascade input) |
| preset_val | input | WIDTH | Value copied into the register on preset |
| count | output | WIDTH | Current register value |
| term | output | 1 | Terminal count: register all ones and `chain_en` high |

## Verification
The bench builds the counter at its default width of 4. At that width all 16 register states can be paired with all 16 combinations of the four control pins, so every mode transition, both wrap-around paths and each priority conflict are checked exhaustively against an arithmetic model. A second 4-bit instance is chained through `term`, which brings the full 256-state sequence of an 8-bit cascade within reach, including the carries at each boundary of the low stage.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    MODE_CLEAR = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_COUNT = 2'd2,
    MODE_HOLD  = 2'd3
  } mode_t;
endpackage

// File: rtl/cnt_mode_sel.sv
module cnt_mode_sel
  import cnt_pkg::*;
(
  input  logic  zero_n,
  input  logic  preset_n,
  input  logic  cnt_en,
  input  logic  chain_en,
  output mode_t mode
);
  // Fixed priority: clear, then preset, then count, then hold.
  always_comb begin
    if (!zero_n)                 mode = MODE_CLEAR;
    else if (!preset_n)          mode = MODE_LOAD;
    else if (cnt_en && chain_en) mode = MODE_COUNT;
    else                         mode = MODE_HOLD;
  end
endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  mode_t            mode,
  input  logic [WIDTH-1:0] preset_val,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] next_val;

  always_comb begin
    case (mode)
      MODE_CLEAR: next_val = ZERO;
      MODE_LOAD:  next_val = preset_val;
      MODE_COUNT: next_val = count + ONE;
      default:    next_val = count;
    endcase
  end

  always_ff @(posedge clk) begin
    count <= next_val;
  end

  // Assertion gating: the register has no reset, so checks start one edge in.
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  p_clear_r1: assert property (@(posedge clk) disable iff (!armed)
    ($past(mode) == MODE_CLEAR) |-> (count == ZERO));
  p_load_r3: assert property (@(posedge clk) disable iff (!armed)
    ($past(mode) == MODE_LOAD) |-> (count == $past(preset_val)));
  p_incr_r4: assert property (@(posedge clk) disable iff (!armed)
    ($past(mode) == MODE_COUNT) |-> (count == WIDTH'($past(count) + ONE)));
  p_hold_r5: assert property (@(posedge clk) disable iff (!armed)
    ($past(mode) == MODE_HOLD) |-> $stable(count));
  p_wrap_r6: assert property (@(posedge clk) disable iff (!armed)
    (($past(mode) == MODE_COUNT) && ($past(count) == '1)) |-> (count == ZERO));
endmodule

// File: rtl/cnt_term_detect.sv
module cnt_term_detect #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] count,
  input  logic             chain_en,
  output logic             term
);
  // AND chain across the bits, seeded with the chain enable.
  logic [WIDTH:0] all_ones;
  assign all_ones[0] = chain_en;
  for (genvar i = 0; i < WIDTH; i++) begin : g_and
    assign all_ones[i+1] = all_ones[i] & count[i];
  end
  assign term = all_ones[WIDTH];
endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             zero_n,
  input  logic             preset_n,
  input  logic             cnt_en,
  input  logic             chain_en,
  input  logic [WIDTH-1:0] preset_val,
  output logic [WIDTH-1:0] count,
  output logic             term
);
  mode_t mode;

  cnt_mode_sel u_mode (
    .zero_n   (zero_n),
    .preset_n (preset_n),
    .cnt_en   (cnt_en),
    .chain_en (chain_en),
    .mode     (mode)
  );

  cnt_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk        (clk),
    .mode       (mode),
    .preset_val (preset_val),
    .count      (count)
  );

  cnt_term_detect #(.WIDTH(WIDTH)) u_term (
    .count    (count),
    .chain_en (chain_en),
    .term     (term)
  );

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  p_term_r7: assert property (@(posedge clk) disable iff (!armed)
    term == ((count == '1) && chain_en));
  p_term_gate_r7: assert property (@(posedge clk) disable iff (!armed)
    !chain_en |-> !term);
endmodule

// File: tb/tb_sync_preset_counter.sv
`timescale 1ns/1ps
module tb_sync_preset_counter;
  localparam int W = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic zero_n, preset_n, cnt_en, chain_en;
  logic [W-1:0] din_lo, din_hi, q_lo, q_hi;
  logic term_lo, term_hi;

  sync_preset_counter #(.WIDTH(W)) dut (
    .clk(clk), .zero_n(zero_n), .preset_n(preset_n), .cnt_en(cnt_en),
    .chain_en(chain_en), .preset_val(din_lo), .count(q_lo), .term(term_lo));

  sync_preset_counter #(.WIDTH(W)) dut_hi (
    .clk(clk), .zero_n(zero_n), .preset_n(preset_n), .cnt_en(cnt_en),
    .chain_en(term_lo), .preset_val(din_hi), .count(q_hi), .term(term_hi));

  int checks = 0;
  int fails  = 0;
  int m_lo = 0;
  int m_hi = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string tag_for(input logic z, input logic p, input logic e1, input logic e2, input int lo);
    if (!z) return "R1";
    if (!p) return "R3";
    if (e1 && e2) return (lo == 15) ? "R6" : "R4";
    return "R5";
  endfunction

  // One clock: inputs set at the falling edge, model stepped at the rising edge,
  // outputs sampled 1 ns later.
  task automatic step(input logic z, input logic p, input logic e1, input logic e2,
                      input int dl, input int dh);
    int lo_term;
    string t;
    @(negedge clk);
    zero_n = z; preset_n = p; cnt_en = e1; chain_en = e2;
    din_lo = W'(dl); din_hi = W'(dh);
    t = tag_for(z, p, e1, e2, m_lo);
    lo_term = (m_lo == 15 && e2) ? 1 : 0;
    @(posedge clk);
    if (!z)       begin m_lo = 0;  m_hi = 0;  end
    else if (!p)  begin m_lo = dl; m_hi = dh; end
    else begin
      if (e1 && e2)           m_lo = (m_lo + 1) % 16;
      if (e1 && lo_term == 1) m_hi = (m_hi + 1) % 16;
    end
    #1;
    check(t, int'(q_lo), m_lo);
    check("R8", int'(q_hi), m_hi);
    check("R7", int'(term_lo), (m_lo == 15 && e2) ? 1 : 0);
  endtask

  initial begin
    #(5ns * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    zero_n = 1'b0; preset_n = 1'b1; cnt_en = 1'b1; chain_en = 1'b1;
    din_lo = '0; din_hi = '0;
    // Reset state through the synchronous clear (R1).
    step(0, 1, 1, 1, 0, 0);
    step(0, 0, 1, 1, 9, 9);

    // Exhaustive: every start value by every control combination.
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 16; c++) begin
        step(1, 0, 0, 0, s, 15 - s);   // preset with enables low (R3)
        step(c[3], c[2], c[1], c[0], (s * 7 + 3) % 16, s);
      end
    end

    // Clear applies with enables low, from all ones (R1).
    step(1, 0, 0, 0, 15, 15);
    step(0, 0, 0, 0, 5, 5);

    // R2: a mid-cycle drop of zero_n does not touch the count before the edge.
    step(1, 0, 0, 0, 11, 2);
    @(negedge clk);
    zero_n = 1'b0;
    #1;
    check("R2", int'(q_lo), 11);
    check("R2", int'(q_hi), 2);
    @(posedge clk); #1;
    m_lo = 0; m_hi = 0;
    check("R2", int'(q_lo), 0);

    // R7: term follows chain_en with no edge.
    step(1, 0, 0, 1, 15, 0);
    @(negedge clk);
    preset_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b0;
    #1;
    check("R7", int'(term_lo), 0);
    chain_en = 1'b1;
    #1;
    check("R7", int'(term_lo), 1);
    chain_en = 1'b0;
    @(posedge clk); #1;

    // R8: cascade counts 300 steps as one 8-bit value.
    step(0, 1, 0, 0, 0, 0);
    for (int k = 1; k <= 300; k++) begin
      step(1, 1, 1, 1, 0, 0);
      check("R8", int'({q_hi, q_lo}), k % 256);
    end

    // R5 in cascade: chain enable low freezes both stages.
    step(1, 1, 1, 0, 0, 0);
    step(1, 1, 0, 1, 0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule